// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block turns single requests from an internal master into external memory cycles on a shared address/data bus. A requester raises `req_valid` with an address, write data, a direction flag and a size flag, and keeps them steady until the block pulses `done`. For reads, the returned value is on `rd_data` in that same cycle. Each external cycle has five phases of one base clock each: the address is put on the shared lines with the latch strobe high, then the latch strobe drops while the address is still driven, then two strobe periods, then a hold period, and finally the bus goes back to idle. An active-low wait input can stretch the second strobe period for as long as it is held low.

Three active-low chip selects are decoded from address windows. Each window is a base plus a compare mask, fixed by parameters. When windows overlap, the lowest-numbered select wins. An external master can take the bus with an active-low request. The block first stops driving every bus output, and only one clock later lowers its acknowledge. It grants the bus only between cycles, so a cycle that is held by wait always completes first. While the bus is granted away, internal requests wait.

High impedance is expressed through the output enables `ad_oe` (shared lines) and `ctl_oe` (upper address, strobes, selects and direction). The pad ring turns these into real tristates.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset, `ctl_oe`=1, `ad_oe`=0, `ale`=0, `rd_n`=`wrl_n`=`wrh_n`=1, `rw`=1, all `cs_n` bits 1, `back_n`=1 and `done`=0.
- R2: A cycle drives `ad_out` = address bits 15:0 with `ad_oe`=1 for two clocks. `ale` is high for only the first of these two clocks. The first strobe clock comes two clocks after the `ale` clock. `addr_hi` carries address bits above 15 during the cycle.
- R3: With no wait, the active strobe stays low for exactly two clocks. `done` is high for one clock, in the hold period. For a halfword read, `rd_data` then holds the value that was on `ad_in` during the last strobe clock.
- R4: `rw` is 0 from the address phase through the hold phase of a write cycle. It is 1 during read cycles and while idle.
- R5: A halfword write lowers both `wrl_n` and `wrh_n` and drives the 16-bit data. A byte write (`req_half`=0) replicates the byte onto both lanes. At an even address it lowers only `wrl_n`; at an odd address it lowers only `wrh_n`. `ad_oe` is 0 during read strobes.
- R6: Select i (bit i of `cs_n`) is low during a cycle only when (address XOR base_i) AND mask_i is zero. With the default parameters the windows are: 0x010000–0x01FFFF for select 0, 0x000000–0x03FFFF for select 1, and 0x800000–0xFFFFFF for select 2. All selects are high when idle.
- R7: When several windows match, only the lowest-numbered select goes low.
- R8: When `wait_n` is low at the end of the second strobe clock, the strobe stays low for another clock. A cycle with wait held low at N such edges has a strobe of 2+N clocks.
- R9: When `breq_n` is low in idle, `ctl_oe` and `ad_oe` drop in the next clock. `back_n` goes low one clock after that and stays low while `breq_n` is low.
- R10: A bus request that arrives during a strobe is not granted until the cycle, including any wait extension, has finished. During any strobe, `back_n` and `ctl_oe` stay 1.
- R11: While `back_n` is low, a pending request starts no cycle (no `ale`, no `done`). One clock after `breq_n` returns high, `back_n` and `ctl_oe` are 1, and the pending request then runs to completion.
- R12: For a byte read, `rd_data` is the selected lane of `ad_in`, zero-extended: bits 7:0 at an even address, bits 15:8 at an odd address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Internal request pending, held until `done` |
| req_addr | input | AW | Request address |
| req_wdata | input | 16 | Write data (byte in bits 7:0 for byte writes) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Read result, valid with `done` of a read |
| ad_out | output | 16 | Shared address/data lines, output value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 16 | Shared address/data lines, input value |
| addr_hi | output | AW-16 | Upper address bits |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe |
| wrl_n | output | 1 | Write strobe for bits 7:0 |
| wrh_n | output | 1 | Write strobe for bits 15:8 |
| rw | output | 1 | Direction level: 1 read/idle, 0 write |
| cs_n | output | NCS | Active-low chip selects |
| ctl_oe | output | 1 | Drive enable for upper address, strobes, selects and `rw` |
| wait_n | input | 1 | Active-low wait |
| breq_n | input | 1 | Active-low bus request from an external master |
| back_n | output | 1 | Active-low bus acknowledge |

## Verification
The bench builds the block with its defaults: a 24-bit address, three selects, the wait input enabled, and windows where select 1 covers all of select 0. With that overlap, one address checks the priority rule and other addresses reach a single select or none. Because wait is enabled, strobes of two, four and five clocks can be produced, and a bus request can be timed to land in the middle of a stretched strobe.

// File: rtl/ebc_pkg.sv
`timescale 1ns/1ps
package ebc_pkg;
   localparam int EBC_DW = 16;
   localparam int EBC_LANE = 8;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_LATCH = 3'd2,
      ST_STRB1 = 3'd3,
      ST_STRB2 = 3'd4,
      ST_HOLD  = 3'd5,
      ST_FLOAT = 3'd6,
      ST_GRANT = 3'd7
   } ebc_state_t;
endpackage

// File: rtl/ebc_cs_decode.sv
`timescale 1ns/1ps
module ebc_cs_decode #(
   parameter int AW  = 24,
   parameter int NCS = 3,
   parameter logic [NCS*AW-1:0] CS_BASE = '0,
   parameter logic [NCS*AW-1:0] CS_MASK = '0
) (
   input  logic [AW-1:0]  addr,
   output logic [NCS-1:0] hit
);
   logic [NCS-1:0] raw;

   genvar gi;
   generate
      for (gi = 0; gi < NCS; gi++) begin : g_win
         assign raw[gi] = (((addr ^ CS_BASE[gi*AW +: AW]) & CS_MASK[gi*AW +: AW]) == '0);
         if (gi == 0) begin : g_top
            assign hit[gi] = raw[gi];
         end else begin : g_lower
            assign hit[gi] = raw[gi] & ~(|raw[gi-1:0]);
         end
      end
   endgenerate
endmodule

// File: rtl/ebc_seq.sv
`timescale 1ns/1ps
module ebc_seq
   import ebc_pkg::*;
#(
   parameter bit WAIT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       breq_n,
   input  logic       wait_n,
   output ebc_state_t state_q,
   output logic       start,
   output logic       strobe_end
);
   ebc_state_t state_d;
   logic       stretch;

   generate
      if (WAIT_EN) begin : g_wait
         assign stretch = ~wait_n;
      end else begin : g_nowait
         logic unused_wait;
         assign unused_wait = wait_n;
         assign stretch = 1'b0;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (!breq_n)        state_d = ST_FLOAT;
                   else if (req_valid) state_d = ST_ADDR;
         ST_ADDR:  state_d = ST_LATCH;
         ST_LATCH: state_d = ST_STRB1;
         ST_STRB1: state_d = ST_STRB2;
         ST_STRB2: if (!stretch)       state_d = ST_HOLD;
         ST_HOLD:  state_d = ST_IDLE;
         ST_FLOAT: state_d = ST_GRANT;
         ST_GRANT: if (breq_n)         state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   assign start      = (state_q == ST_IDLE) && (state_d == ST_ADDR);
   assign strobe_end = (state_q == ST_STRB2) && (state_d == ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/ebc_cycle_regs.sv
`timescale 1ns/1ps
module ebc_cycle_regs
   import ebc_pkg::*;
#(
   parameter int AW  = 24,
   parameter int NCS = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              strobe_end,
   input  logic [AW-1:0]     req_addr,
   input  logic [EBC_DW-1:0] req_wdata,
   input  logic              req_write,
   input  logic              req_half,
   input  logic [NCS-1:0]    sel_hit,
   input  logic [EBC_DW-1:0] ad_in,
   output logic [AW-1:0]     addr_q,
   output logic [EBC_DW-1:0] wdata_q,
   output logic              write_q,
   output logic              lo_en_q,
   output logic              hi_en_q,
   output logic [NCS-1:0]    sel_q,
   output logic [EBC_DW-1:0] rdata_q
);
   logic              half_q;
   logic [EBC_DW-1:0] lane_d;
   logic [EBC_DW-1:0] rsel_d;

   always_comb begin
      if (req_half) lane_d = req_wdata;
      else          lane_d = {req_wdata[EBC_LANE-1:0], req_wdata[EBC_LANE-1:0]};
   end

   always_comb begin
      if (half_q)         rsel_d = ad_in;
      else if (addr_q[0]) rsel_d = {{EBC_LANE{1'b0}}, ad_in[EBC_DW-1:EBC_LANE]};
      else                rsel_d = {{EBC_LANE{1'b0}}, ad_in[EBC_LANE-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         write_q <= 1'b0;
         half_q  <= 1'b0;
         lo_en_q <= 1'b0;
         hi_en_q <= 1'b0;
         sel_q   <= '0;
         rdata_q <= '0;
      end else begin
         if (start) begin
            addr_q  <= req_addr;
            wdata_q <= lane_d;
            write_q <= req_write;
            half_q  <= req_half;
            lo_en_q <= req_half | ~req_addr[0];
            hi_en_q <= req_half |  req_addr[0];
            sel_q   <= sel_hit;
         end
         if (strobe_end && !write_q) rdata_q <= rsel_d;
      end
   end
endmodule

// File: rtl/mux_bus_ctrl.sv
`timescale 1ns/1ps
module mux_bus_ctrl
   import ebc_pkg::*;
#(
   parameter int AW  = 24,
   parameter int NCS = 3,
   parameter bit WAIT_EN = 1'b1,
   parameter logic [NCS*AW-1:0] CS_BASE = {24'h800000, 24'h000000, 24'h010000},
   parameter logic [NCS*AW-1:0] CS_MASK = {24'h800000, 24'hFC0000, 24'hFF0000}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AW-1:0]     req_addr,
   input  logic [15:0]       req_wdata,
   input  logic              req_write,
   input  logic              req_half,
   output logic              done,
   output logic [15:0]       rd_data,
   output logic [15:0]       ad_out,
   output logic              ad_oe,
   input  logic [15:0]       ad_in,
   output logic [AW-17:0]    addr_hi,
   output logic              ale,
   output logic              rd_n,
   output logic              wrl_n,
   output logic              wrh_n,
   output logic              rw,
   output logic [NCS-1:0]    cs_n,
   output logic              ctl_oe,
   input  logic              wait_n,
   input  logic              breq_n,
   output logic              back_n
);
   localparam int HIW = AW - EBC_DW;

   generate
      if (AW <= EBC_DW || NCS < 1 || NCS > 8) begin : g_bad_params
         initial $error("mux_bus_ctrl: AW must exceed 16 and NCS must be 1..8");
      end
   endgenerate

   ebc_state_t        state_q;
   logic              start, strobe_end;
   logic [NCS-1:0]    sel_hit, sel_q;
   logic [AW-1:0]     addr_q;
   logic [EBC_DW-1:0] wdata_q, rdata_q;
   logic              write_q, lo_en_q, hi_en_q;
   logic              in_cyc, addr_ph, strb_ph, data_ph;

   ebc_seq #(.WAIT_EN(WAIT_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .breq_n(breq_n),
      .wait_n(wait_n), .state_q(state_q), .start(start), .strobe_end(strobe_end)
   );

   ebc_cs_decode #(.AW(AW), .NCS(NCS), .CS_BASE(CS_BASE), .CS_MASK(CS_MASK)) u_dec (
      .addr(req_addr), .hit(sel_hit)
   );

   ebc_cycle_regs #(.AW(AW), .NCS(NCS)) u_regs (
      .clk(clk), .rst_n(rst_n), .start(start), .strobe_end(strobe_end),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
      .req_half(req_half), .sel_hit(sel_hit), .ad_in(ad_in),
      .addr_q(addr_q), .wdata_q(wdata_q), .write_q(write_q),
      .lo_en_q(lo_en_q), .hi_en_q(hi_en_q), .sel_q(sel_q), .rdata_q(rdata_q)
   );

   always_comb begin
      addr_ph = (state_q == ST_ADDR) || (state_q == ST_LATCH);
      strb_ph = (state_q == ST_STRB1) || (state_q == ST_STRB2);
      data_ph = strb_ph || (state_q == ST_HOLD);
      in_cyc  = addr_ph || data_ph;

      ctl_oe  = (state_q != ST_FLOAT) && (state_q != ST_GRANT);
      back_n  = (state_q != ST_GRANT);
      ad_oe   = addr_ph || (data_ph && write_q);
      if (addr_ph)                 ad_out = addr_q[EBC_DW-1:0];
      else if (data_ph && write_q) ad_out = wdata_q;
      else                         ad_out = '0;
      addr_hi = addr_q[AW-1:AW-HIW];
      ale     = (state_q == ST_ADDR);
      rd_n    = ~(strb_ph && !write_q);
      wrl_n   = ~(strb_ph && write_q && lo_en_q);
      wrh_n   = ~(strb_ph && write_q && hi_en_q);
      rw      = ~(in_cyc && write_q);
      cs_n    = in_cyc ? ~sel_q : '1;
      done    = (state_q == ST_HOLD);
      rd_data = rdata_q;
   end
endmodule

// File: rtl/ebc_chk.sv
`timescale 1ns/1ps
module ebc_chk #(
   parameter int AW  = 24,
   parameter int NCS = 3,
   parameter bit WAIT_EN = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ale,
   input logic           ad_oe,
   input logic           rd_n,
   input logic           wrl_n,
   input logic           wrh_n,
   input logic           rw,
   input logic [NCS-1:0] cs_n,
   input logic           ctl_oe,
   input logic           wait_n,
   input logic           back_n,
   input logic           done,
   input logic [AW-17:0] addr_hi
);
   logic any_strb;
   logic unused_hi;
   assign any_strb  = ~rd_n | ~wrl_n | ~wrh_n;
   assign unused_hi = ^addr_hi;

   // R2
   latch_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> (!$past(ale) && $past(ad_oe)));

   // R2
   ale_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (rd_n && wrl_n && wrh_n && ad_oe));

   // R3
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   write_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrl_n || !wrh_n) |-> !rw);

   // R7
   cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R8
   wait_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (WAIT_EN && !rd_n && !$past(rd_n) && !wait_n) |=> !rd_n);

   // R9
   float_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(back_n) |-> ($past(!ctl_oe) && $past(!ad_oe)));

   // R9
   granted_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !back_n |-> (!ctl_oe && !ad_oe));

   // R10
   no_grant_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_strb |-> (back_n && ctl_oe));

   // R11
   no_cycle_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !back_n |-> (!ale && !done));
endmodule

bind mux_bus_ctrl ebc_chk #(.AW(AW), .NCS(NCS), .WAIT_EN(WAIT_EN)) u_chk (.*);

// File: tb/sim_mux_bus_ctrl.sv
`timescale 1ns/1ps
module sim_mux_bus_ctrl;
   localparam int AW = 24;
   localparam int NCS = 3;
   localparam logic [15:0] RDV = 16'hA55A;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [15:0]    req_wdata = '0;
   logic           req_write = 1'b0;
   logic           req_half = 1'b1;
   logic           done;
   logic [15:0]    rd_data;
   logic [15:0]    ad_out;
   logic           ad_oe;
   logic [15:0]    ad_in = RDV;
   logic [AW-17:0] addr_hi;
   logic           ale, rd_n, wrl_n, wrh_n, rw, ctl_oe, back_n;
   logic [NCS-1:0] cs_n;
   logic           wait_n = 1'b1;
   logic           breq_n = 1'b1;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mux_bus_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_half(req_half),
      .done(done), .rd_data(rd_data), .ad_out(ad_out), .ad_oe(ad_oe),
      .ad_in(ad_in), .addr_hi(addr_hi), .ale(ale), .rd_n(rd_n),
      .wrl_n(wrl_n), .wrh_n(wrh_n), .rw(rw), .cs_n(cs_n), .ctl_oe(ctl_oe),
      .wait_n(wait_n), .breq_n(breq_n), .back_n(back_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic check_reset();
      @(negedge clk);
      chk(ctl_oe == 1'b1, "R1", "ctl_oe", ctl_oe, 1);
      chk(ad_oe == 1'b0, "R1", "ad_oe", ad_oe, 0);
      chk(ale == 1'b0, "R1", "ale", ale, 0);
      chk({rd_n, wrl_n, wrh_n} == 3'b111, "R1", "strobes", {rd_n, wrl_n, wrh_n}, 7);
      chk(rw == 1'b1, "R1", "rw", rw, 1);
      chk(cs_n == 3'b111, "R1", "cs_n", cs_n, 7);
      chk(back_n == 1'b1 && done == 1'b0, "R1", "back_n/done", {back_n, done}, 2);
   endtask

   // One external cycle; checks phases, strobes, lanes, selects and (optionally) a
   // bus request raised during the first strobe clock.
   task automatic run_cycle(input logic [AW-1:0] a, input logic [15:0] wd,
                            input bit wr, input bit half, input int waits,
                            input logic [2:0] exp_cs, input string cs_req,
                            input bit breq_mid);
      int ale_cnt = 0, ale_k = -10, first_k = -1, strb = 0;
      int rd_cnt = 0, wl_cnt = 0, wh_cnt = 0, done_cnt = 0, done_k = -1;
      int rw_bad = 0, oe_bad = 0, rel_bad = 0, latch_ok = 0;
      logic [15:0] seen_ad = '0, seen_wd = '0, seen_rd = '0;
      logic [AW-17:0] seen_hi = '0;
      logic [2:0] seen_cs = 3'b111;
      logic [15:0] exp_rd, exp_wd;
      int len;
      bit fin = 0;
      len = 2 + waits;
      exp_rd = half ? RDV : (a[0] ? {8'h00, RDV[15:8]} : {8'h00, RDV[7:0]});
      exp_wd = half ? wd : {wd[7:0], wd[7:0]};
      req_addr = a; req_wdata = wd; req_write = wr; req_half = half;
      req_valid = 1'b1;
      wait_n = 1'b1;
      for (int k = 0; k < 60 && !fin; k++) begin
         @(negedge clk);
         if (ale) begin
            ale_cnt++; ale_k = k; seen_ad = ad_out; seen_hi = addr_hi;
         end
         if (k == ale_k + 1 && !ale && ad_oe && ad_out == a[15:0]) latch_ok = 1;
         if (!rd_n || !wrl_n || !wrh_n) begin
            strb++;
            if (first_k < 0) first_k = k;
            seen_cs = cs_n;
            if (wr) begin
               seen_wd = ad_out;
               if (!ad_oe || rw) rw_bad++;
            end else if (ad_oe || !rw) oe_bad++;
            if (!ctl_oe || !back_n) rel_bad++;
            wait_n = (strb >= 2 + waits);
            if (breq_mid && strb == 1) breq_n = 1'b0;
         end
         if (!rd_n) rd_cnt++;
         if (!wrl_n) wl_cnt++;
         if (!wrh_n) wh_cnt++;
         if (done) begin
            done_cnt++; done_k = k; seen_rd = rd_data; req_valid = 1'b0;
            chk(rw == !wr, "R4", "rw in hold", rw, !wr);
         end
         if (done_k >= 0 && !breq_mid && k == done_k + 1) begin
            chk(cs_n == 3'b111, "R6", "cs_n idle", cs_n, 7);
            chk(rw == 1'b1, "R4", "rw idle", rw, 1);
            fin = 1;
         end
         if (done_k >= 0 && breq_mid) begin
            if (k == done_k + 2) begin
               chk(!ctl_oe && !ad_oe && back_n, "R10", "float after cycle",
                   {ctl_oe, ad_oe, back_n}, 1);
            end
            if (k == done_k + 3) begin
               chk(!back_n && !ctl_oe, "R10", "ack after cycle", {back_n, ctl_oe}, 0);
               breq_n = 1'b1;
            end
            if (k == done_k + 4) begin
               chk(back_n && ctl_oe, "R11", "bus back", {back_n, ctl_oe}, 3);
               fin = 1;
            end
         end
      end
      wait_n = 1'b1;
      chk(ale_cnt == 1, "R2", "ale clocks", ale_cnt, 1);
      chk(seen_ad == a[15:0], "R2", "address on shared lines", seen_ad, a[15:0]);
      chk(seen_hi == a[AW-1:16], "R2", "upper address", seen_hi, a[AW-1:16]);
      chk(latch_ok == 1, "R2", "latch phase", latch_ok, 1);
      chk(first_k == ale_k + 2, "R2", "strobe start", first_k - ale_k, 2);
      chk(strb == len, (waits == 0) ? "R3" : "R8", "strobe length", strb, len);
      chk(done_cnt == 1, "R3", "done pulses", done_cnt, 1);
      chk(seen_cs == exp_cs, cs_req, "cs_n in cycle", seen_cs, exp_cs);
      chk(rel_bad == 0, "R10", "release during strobe", rel_bad, 0);
      if (wr) begin
         chk(rw_bad == 0, "R4", "rw/oe during write", rw_bad, 0);
         chk(seen_wd == exp_wd, "R5", "write lanes", seen_wd, exp_wd);
         chk(wl_cnt == ((half || !a[0]) ? len : 0), "R5", "wrl_n clocks", wl_cnt,
             (half || !a[0]) ? len : 0);
         chk(wh_cnt == ((half || a[0]) ? len : 0), "R5", "wrh_n clocks", wh_cnt,
             (half || a[0]) ? len : 0);
         chk(rd_cnt == 0, "R5", "rd_n in write", rd_cnt, 0);
      end else begin
         chk(oe_bad == 0, "R5", "read drive off", oe_bad, 0);
         chk(seen_rd == exp_rd, half ? "R3" : "R12", "read data", seen_rd, exp_rd);
         chk(wl_cnt + wh_cnt == 0, "R4", "write strobes in read", wl_cnt + wh_cnt, 0);
      end
   endtask

   task automatic grant_and_stall();
      @(negedge clk);
      breq_n = 1'b0;
      @(negedge clk);
      chk(!ctl_oe && !ad_oe, "R9", "float first", {ctl_oe, ad_oe}, 0);
      chk(back_n == 1'b1, "R9", "ack not yet", back_n, 1);
      @(negedge clk);
      chk(back_n == 1'b0, "R9", "ack low", back_n, 0);
      req_addr = 24'h010002; req_write = 1'b0; req_half = 1'b1; req_valid = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(!ale && !done && !back_n, "R11", "stalled while granted",
             {ale, done, back_n}, 0);
      end
      breq_n = 1'b1;
      @(negedge clk);
      chk(back_n && ctl_oe, "R11", "ack withdrawn", {back_n, ctl_oe}, 3);
      begin
         int got = 0;
         for (int k = 0; k < 12 && got == 0; k++) begin
            @(negedge clk);
            if (done) begin
               got = 1;
               chk(rd_data == RDV, "R11", "stalled read data", rd_data, RDV);
               req_valid = 1'b0;
            end
         end
         chk(got == 1, "R11", "stalled request completed", got, 1);
      end
      @(negedge clk);
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_reset();
      run_cycle(24'h010004, 16'h0000, 1'b0, 1'b1, 0, 3'b110, "R7", 1'b0);
      run_cycle(24'h020010, 16'hBEEF, 1'b1, 1'b1, 0, 3'b101, "R6", 1'b0);
      run_cycle(24'h812346, 16'h005A, 1'b1, 1'b0, 0, 3'b011, "R6", 1'b0);
      run_cycle(24'h812347, 16'h00C3, 1'b1, 1'b0, 0, 3'b011, "R6", 1'b0);
      run_cycle(24'h050001, 16'h0000, 1'b0, 1'b0, 0, 3'b111, "R6", 1'b0);
      run_cycle(24'h050000, 16'h0000, 1'b0, 1'b0, 0, 3'b111, "R6", 1'b0);
      run_cycle(24'h010000, 16'h0000, 1'b0, 1'b1, 3, 3'b110, "R7", 1'b0);
      run_cycle(24'h030000, 16'h1234, 1'b1, 1'b1, 2, 3'b101, "R6", 1'b0);
      grant_and_stall();
      run_cycle(24'h800100, 16'h0000, 1'b0, 1'b1, 4, 3'b011, "R6", 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule